// File: doc/BRIEF.md
# Low-Power-Aware Watchdog Timer

This block is a watchdog counter that detects runaway software. It advances on tick strobes from one of two operating clocks, chosen by a select input. Unless software clears it first, it raises a one-cycle timeout pulse when it reaches a programmable terminal count, and then starts again from zero.

Two low-power states are signalled from outside: a light sleep (halt) and a deep sleep (stop). In either state the count is frozen rather than reset. After a halt, counting resumes at once. After a stop, the block first waits a programmable oscillator-settling period, then a fixed 17-tick exit delay, and only then counts again. The clock choice is captured on entry to sleep, so the same clock drives the count on resumption.

The sequencer has five states:

| State | Meaning |
|---|---|
| RUN | counting |
| HALTED | halt freeze |
| STOPPED | stop freeze |
| STAB | oscillator settling |
| SETTLE | fixed exit delay |

Its transitions:

- RUN to STOPPED, on the stop request.
- RUN to HALTED, on the halt request while halt freezing is enabled.
- HALTED to RUN, when the halt request drops.
- HALTED to STOPPED, on the stop request.
- STOPPED to STAB, when the stop request drops.
- STAB to SETTLE, when the settling ticks are done.
- SETTLE to RUN, after 17 ticks.

Top module: `lpwdt_top`

## Requirements
- R1: In RUN, the count rises by one on each selected tick. Select value 0 picks `tick_main_i` and 1 picks `tick_ring_i`.
- R2: A selected tick while the count is at or above `term_i` sets the count to 0. `timeout_o` is then high for exactly the one cycle after that edge.
- R3: `clr_i` zeroes the count only in RUN with no freeze request in the same cycle, and then no timeout is raised even on a terminal tick. In any other case it has no effect on the count.
- R4: `stop_i` high in RUN freezes the count, whatever `sw_stop_cfg_i` holds. The frozen value is kept through the whole stop exit and is never cleared.
- R5: `halt_i` freezes the count only when `sw_stop_cfg_i` is 1. With it 0, counting continues while `halt_i` is high.
- R6: A freeze request in the same cycle as a tick (including a terminal tick) wins. The count does not move and no timeout is raised.
- R7: The edge after `halt_i` drops returns HALTED to RUN without counting. Counting resumes on the following ticks with the count unchanged.
- R8: After `stop_i` drops, one edge moves STOPPED to STAB. STAB lasts max(`stab_len_i`,1) selected ticks, and its last tick pulses `stab_done_o` for one cycle. SETTLE then lasts 17 selected ticks, and `run_o` rises at the edge of the last one.
- R9: The select input is captured at sleep entry and held until the next accepted clear, so select changes made during sleep are ignored. After the clear, the select is followed again with one cycle of lag.
- R10: After reset, count is 0, `timeout_o` and `stab_done_o` are 0, `run_o` is 1 and main tick is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| tick_main_i | input | 1 | tick strobe of the main operating clock |
| tick_ring_i | input | 1 | tick strobe of the internal ring clock |
| src_sel_i | input | 1 | operating clock choice, 0 main, 1 ring |
| sw_stop_cfg_i | input | 1 | enables the halt freeze |
| halt_i | input | 1 | halt state request |
| stop_i | input | 1 | stop state request |
| clr_i | input | 1 | clear/restart strobe |
| term_i | input | CNT_W | terminal count |
| stab_len_i | input | OST_W | oscillator settling length in ticks |
| count_o | output | CNT_W | current count |
| timeout_o | output | 1 | one-cycle timeout pulse |
| stab_done_o | output | 1 | settling period finished pulse |
| run_o | output | 1 | sequencer is in RUN |

## Verification
Two pairs of functions can land in the same cycle, and each is driven so. A clear strobe can meet a tick at the terminal count. A halt request can also arrive on that same terminal tick. The bench first walks the count up to the terminal value, then raises both inputs on the next tick. In the clear case it expects a zero count with no timeout pulse. In the halt case it expects the terminal value held and no pulse, and the delayed wrap and pulse only after resuming.

// File: rtl/lpwdt_pkg.sv
package lpwdt_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_HALTED,
        ST_STOPPED,
        ST_STAB,
        ST_SETTLE
    } wdt_state_e;
endpackage

// File: rtl/lpwdt_fsm.sv
module lpwdt_fsm
    import lpwdt_pkg::*;
#(
    parameter int OST_W      = 8,
    parameter int EXIT_TICKS = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_i,
    input  logic             stop_i,
    input  logic             sw_stop_cfg_i,
    input  logic             tick_i,
    input  logic [OST_W-1:0] stab_len_i,
    output logic             count_en_o,
    output logic             lp_enter_o,
    output logic             run_o,
    output logic             stab_done_o
);
    localparam int EX_W  = $clog2(EXIT_TICKS + 1);
    localparam int DLY_W = ((EX_W > OST_W) ? EX_W : OST_W) + 1;

    wdt_state_e       state_q, state_d;
    logic [DLY_W-1:0] dly_q;
    logic             freeze_req;
    logic             stab_last;
    logic             settle_last;

    assign freeze_req  = stop_i | (halt_i & sw_stop_cfg_i);
    assign stab_last   = (dly_q + 1'b1) >= DLY_W'(stab_len_i);
    assign settle_last = dly_q == DLY_W'(EXIT_TICKS - 1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (stop_i)                         state_d = ST_STOPPED;
                else if (halt_i && sw_stop_cfg_i)   state_d = ST_HALTED;
            end
            ST_HALTED: begin
                if (stop_i)       state_d = ST_STOPPED;
                else if (!halt_i) state_d = ST_RUN;
            end
            ST_STOPPED: if (!stop_i)                 state_d = ST_STAB;
            ST_STAB:    if (tick_i && stab_last)     state_d = ST_SETTLE;
            ST_SETTLE:  if (tick_i && settle_last)   state_d = ST_RUN;
            default:                                 state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_RUN;
            dly_q       <= '0;
            stab_done_o <= 1'b0;
        end else begin
            state_q     <= state_d;
            stab_done_o <= (state_q == ST_STAB) && (state_d == ST_SETTLE);
            if (state_q != state_d)
                dly_q <= '0;
            else if (tick_i && (state_q == ST_STAB || state_q == ST_SETTLE))
                dly_q <= dly_q + 1'b1;
        end
    end

    always_comb begin
        count_en_o = (state_q == ST_RUN) && !freeze_req;
        lp_enter_o = (state_q == ST_RUN) && freeze_req;
        run_o      = (state_q == ST_RUN);
    end

    // R4
    stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && stop_i) |=> (state_q == ST_STOPPED));

    // R8
    stab_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stab_done_o |-> (state_q == ST_SETTLE));

    // R7
    run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) != ST_RUN) |->
        ($past(state_q) == ST_HALTED || $past(state_q) == ST_SETTLE));
endmodule

// File: rtl/lpwdt_clksel.sv
module lpwdt_clksel (
    input  logic clk,
    input  logic rst_n,
    input  logic src_sel_i,
    input  logic tick_main_i,
    input  logic tick_ring_i,
    input  logic run_i,
    input  logic lp_enter_i,
    input  logic clr_i,
    input  logic en_i,
    output logic tick_o
);
    logic sel_q;
    logic lock_q;
    logic clr_acc;

    assign clr_acc = clr_i & en_i;
    assign tick_o  = sel_q ? tick_ring_i : tick_main_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            if (lp_enter_i) begin
                sel_q  <= src_sel_i;
                lock_q <= 1'b1;
            end else begin
                if (run_i && !lock_q) sel_q <= src_sel_i;
                if (clr_acc)          lock_q <= 1'b0;
            end
        end
    end

    // R9
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !lp_enter_i) |=> $stable(sel_q));
endmodule

// File: rtl/lpwdt_counter.sv
module lpwdt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] term_i,
    output logic [CNT_W-1:0] count_o,
    output logic             timeout_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o   <= '0;
            timeout_o <= 1'b0;
        end else begin
            timeout_o <= 1'b0;
            if (en_i) begin
                if (clr_i) begin
                    count_o <= '0;
                end else if (tick_i) begin
                    if (count_o >= term_i) begin
                        count_o   <= '0;
                        timeout_o <= 1'b1;
                    end else begin
                        count_o <= count_o + 1'b1;
                    end
                end
            end
        end
    end

    // R2
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (count_o == '0));

    // R6
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(count_o));
endmodule

// File: rtl/lpwdt_top.sv
module lpwdt_top #(
    parameter int CNT_W      = 16,
    parameter int OST_W      = 8,
    parameter int EXIT_TICKS = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_main_i,
    input  logic             tick_ring_i,
    input  logic             src_sel_i,
    input  logic             sw_stop_cfg_i,
    input  logic             halt_i,
    input  logic             stop_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] term_i,
    input  logic [OST_W-1:0] stab_len_i,
    output logic [CNT_W-1:0] count_o,
    output logic             timeout_o,
    output logic             stab_done_o,
    output logic             run_o
);
    logic count_en;
    logic lp_enter;
    logic tick_sel;

    lpwdt_fsm #(.OST_W(OST_W), .EXIT_TICKS(EXIT_TICKS)) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .halt_i        (halt_i),
        .stop_i        (stop_i),
        .sw_stop_cfg_i (sw_stop_cfg_i),
        .tick_i        (tick_sel),
        .stab_len_i    (stab_len_i),
        .count_en_o    (count_en),
        .lp_enter_o    (lp_enter),
        .run_o         (run_o),
        .stab_done_o   (stab_done_o)
    );

    lpwdt_clksel clksel_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_sel_i   (src_sel_i),
        .tick_main_i (tick_main_i),
        .tick_ring_i (tick_ring_i),
        .run_i       (run_o),
        .lp_enter_i  (lp_enter),
        .clr_i       (clr_i),
        .en_i        (count_en),
        .tick_o      (tick_sel)
    );

    lpwdt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (count_en),
        .tick_i    (tick_sel),
        .clr_i     (clr_i),
        .term_i    (term_i),
        .count_o   (count_o),
        .timeout_o (timeout_o)
    );
endmodule

// File: tb/lpwdt_top_tb_top.sv
`timescale 1ns/1ps
module lpwdt_top_tb_top;
    localparam int CNT_W = 16;
    localparam int OST_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_main = 0, tick_ring = 0, src_sel = 0, cfg = 1;
    logic halt = 0, stop = 0, clr = 0;
    logic [CNT_W-1:0] term = 16'd3;
    logic [OST_W-1:0] stab_len = 8'd4;
    logic [CNT_W-1:0] count;
    logic timeout, stab_done, run;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    lpwdt_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick_main_i(tick_main), .tick_ring_i(tick_ring),
        .src_sel_i(src_sel), .sw_stop_cfg_i(cfg), .halt_i(halt), .stop_i(stop),
        .clr_i(clr), .term_i(term), .stab_len_i(stab_len), .count_o(count),
        .timeout_o(timeout), .stab_done_o(stab_done), .run_o(run)
    );

    // {halt, stop, clr, tick_main, expected count, expected timeout}
    localparam logic [20:0] VEC [16] = '{
        {4'b0001, 16'd1, 1'b0}, {4'b0001, 16'd2, 1'b0}, {4'b0000, 16'd2, 1'b0},
        {4'b0001, 16'd3, 1'b0}, {4'b0001, 16'd0, 1'b1}, {4'b0001, 16'd1, 1'b0},
        {4'b0011, 16'd0, 1'b0}, {4'b0001, 16'd1, 1'b0}, {4'b1001, 16'd1, 1'b0},
        {4'b1001, 16'd1, 1'b0}, {4'b0001, 16'd1, 1'b0}, {4'b0001, 16'd2, 1'b0},
        {4'b1011, 16'd2, 1'b0}, {4'b1010, 16'd2, 1'b0}, {4'b0000, 16'd2, 1'b0},
        {4'b0001, 16'd3, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 0; tick_main = 0; tick_ring = 0; halt = 0; stop = 0; clr = 0; src_sel = 0;
        #12;
        rst_n = 1;
        step();
    endtask

    task automatic stop_exit(input string req, input int slen, input int exp_run, input int exp_sd);
        int run_edge = 0;
        int sd_edge  = 0;
        int sd_cnt   = 0;
        logic [CNT_W-1:0] held;
        held = count;
        stab_len = OST_W'(slen);
        stop = 0; tick_main = 1;
        for (int e = 1; e <= 40 && run_edge == 0; e++) begin
            step();
            if (stab_done) begin sd_cnt++; sd_edge = e; end
            if (run) run_edge = e;
        end
        chk({req, " R8 run edge"}, run_edge, exp_run);
        chk({req, " R8 stab_done edge"}, sd_edge, exp_sd);
        chk({req, " R8 stab_done count"}, sd_cnt, 1);
        chk({req, " R4 held count"}, int'(count), int'(held));
        step();
        chk({req, " R4 resumed count"}, int'(count), int'(held) + 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10 reset state
        chk("R10 count", int'(count), 0);
        chk("R10 timeout", int'(timeout), 0);
        chk("R10 stab_done", int'(stab_done), 0);
        chk("R10 run", int'(run), 1);

        // R1 R2 R3 R6 R7 vector walk, term 3, cfg 1
        for (int i = 0; i < 16; i++) begin
            {halt, stop, clr, tick_main} = VEC[i][20:17];
            step();
            chk($sformatf("R1/R2/R3/R7 row %0d count", i), int'(count), int'(VEC[i][16:1]));
            chk($sformatf("R2 row %0d timeout", i), int'(timeout), int'(VEC[i][0]));
        end
        halt = 0; clr = 0; tick_main = 0;

        // R3 clear on terminal tick: no timeout
        term = 16'd2; do_reset();
        tick_main = 1; step(); step();
        clr = 1; step(); clr = 0; tick_main = 0;
        chk("R3 clear beats terminal count", int'(count), 0);
        chk("R3 clear beats terminal timeout", int'(timeout), 0);

        // R6 halt on terminal tick
        do_reset();
        tick_main = 1; step(); step();
        halt = 1; step();
        chk("R6 freeze beats terminal count", int'(count), 2);
        chk("R6 freeze beats terminal timeout", int'(timeout), 0);
        halt = 0; tick_main = 0; step();
        chk("R7 halt exit run", int'(run), 1);
        chk("R7 halt exit count", int'(count), 2);
        tick_main = 1; step(); tick_main = 0;
        chk("R2 wrap after resume count", int'(count), 0);
        chk("R2 wrap after resume timeout", int'(timeout), 1);
        step();
        chk("R2 timeout one cycle", int'(timeout), 0);

        // R5 halt ignored when cfg 0
        term = 16'd100; cfg = 0; do_reset();
        halt = 1; tick_main = 1; step(); step(); step();
        chk("R5 count runs in halt", int'(count), 3);
        chk("R5 run stays high", int'(run), 1);
        halt = 0;

        // R4 R8 stop freeze with cfg 0, stab_len 4
        stop = 1; step();
        chk("R4 stop count frozen", int'(count), 3);
        chk("R4 stop leaves run", int'(run), 0);
        step(); step(); step();
        chk("R4 count held in stop", int'(count), 3);
        stop_exit("len4", 4, 22, 5);

        // R8 stab_len 0 with cfg 1
        cfg = 1; do_reset();
        tick_main = 1; step(); step();
        stop = 1; step(); step();
        stop_exit("len0", 0, 19, 2);
        tick_main = 0;

        // R9 select captured at entry
        do_reset();
        src_sel = 1; step();
        halt = 1; step();
        src_sel = 0; step();
        halt = 0; step();
        tick_main = 1; step(); tick_main = 0;
        chk("R9 main tick ignored after resume", int'(count), 0);
        tick_ring = 1; step(); tick_ring = 0;
        chk("R9 ring tick counts after resume", int'(count), 1);
        clr = 1; step(); clr = 0;
        chk("R3 clear accepted", int'(count), 0);
        step();
        tick_main = 1; step(); tick_main = 0;
        chk("R9 select follows after clear", int'(count), 1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule